// File: doc/BRIEF.md
# Main Interrupt Cause Aggregator

This block gathers up to 64 level-sensitive interrupt sources into a 64-bit cause vector. It qualifies that vector with a 64-bit CPU enable mask and drives a single registered interrupt line toward the processor. Each cause bit mirrors its source level one clock later. Software cannot set or clear a cause bit; a source only drops its request when the peripheral behind it is serviced.

Software sees the block through a small register window. The cause and the mask each read as a low and a high 32-bit half. Each mask half is written on its own. A fifth read location, the select view, returns whichever half holds a pending enabled source and flags which half it returned. An interrupt handler can therefore find its work with one read.

The design is pure datapath and has no sequencing states. It has three registers (cause, mask, interrupt line) and one combinational read multiplexer.

Top module: `irq_cause_agg`

## Requirements
- R1: On each clock, every non-reserved cause bit takes the level its source input had before that edge. No write changes the cause.
- R2: Reserved cause bits 29, 30, 31, 35, 51 to 55 and 61 to 63 always read 0, whatever their source inputs do.
- R3: A write with `wr_hi_i`=0 loads mask bits 31:0 from `wr_data_i` and leaves mask bits 63:32 unchanged.
- R4: A write with `wr_hi_i`=1 loads mask bits 63:32 from `wr_data_i` and leaves mask bits 31:0 unchanged.
- R5: `irq_o` is a registered signal. It is 1 exactly when (cause AND mask) was nonzero after the previous clock edge, so it follows a source or mask change one clock later.
- R6: Select view (address 4) with no enabled cause pending returns cause bits 31:0 unmodified.
- R7: Select view with enabled causes pending only in bits 63:32 returns cause bits 63:32 with bit 30 set.
- R8: Select view with enabled causes pending in both halves returns cause bits 31:0 with bit 31 set.
- R9: Select view with enabled causes pending only in bits 31:0 returns cause bits 31:0 with no flag bit set.
- R10: After reset the cause, the mask and `irq_o` are all 0.
- R11: The read address map is 0 = cause low, 1 = cause high, 2 = mask low, 3 = mask high, 4 = select view. Addresses 5 to 7 read 0. Reads are combinational from registered state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_i | input | 64 | Level interrupt sources, one per cause bit |
| wr_en_i | input | 1 | Mask half write strobe |
| wr_hi_i | input | 1 | Selects the mask half written: 0 low, 1 high |
| wr_data_i | input | 32 | Mask half write data |
| rd_addr_i | input | 3 | Read location select |
| rd_data_o | output | 32 | Read data for the selected location |
| irq_o | output | 1 | CPU interrupt request |

## Verification
The hardest case to reach is the select view with enabled sources pending in both halves at once. Reaching it needs a source asserted in each half and both mask halves written non-zero. The case of a cause that is pending but masked in one half is equally hard to reach. The bench builds a grid of cause patterns (none, low only, high only, both) crossed with every mask pattern (no half, low half, high half, both halves). It compares the select view and the interrupt line against a model kept in the bench for every point on that grid.

// File: rtl/irq_cause_pkg.sv
package irq_cause_pkg;
    localparam int HALF_W = 32;
    localparam int VEC_W  = 2 * HALF_W;

    typedef enum logic [2:0] {
        RA_CAUSE_LO = 3'd0,
        RA_CAUSE_HI = 3'd1,
        RA_MASK_LO  = 3'd2,
        RA_MASK_HI  = 3'd3,
        RA_SELECT   = 3'd4
    } rd_addr_e;

    // Reserved cause positions: 29..31, 35, 51..55, 61..63
    localparam logic [VEC_W-1:0] RSVD_DEFAULT = 64'hE0F8_0008_E000_0000;
endpackage

// File: rtl/cause_capture.sv
module cause_capture #(
    parameter int             W    = 64,
    parameter logic [W-1:0]   RSVD = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] src_i,
    output logic [W-1:0] cause_d,
    output logic [W-1:0] cause_q
);
    assign cause_d = src_i & ~RSVD;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cause_q <= '0;
        else        cause_q <= cause_d;
    end
endmodule

// File: rtl/mask_halves.sv
module mask_halves #(
    parameter int HW = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en_i,
    input  logic            wr_hi_i,
    input  logic [HW-1:0]   wr_data_i,
    output logic [2*HW-1:0] mask_d,
    output logic [2*HW-1:0] mask_q
);
    localparam int NHALF = 2;

    for (genvar h = 0; h < NHALF; h++) begin : g_half
        localparam logic HSEL = 1'(h);
        logic hit;
        assign hit = wr_en_i && (wr_hi_i == HSEL);
        assign mask_d[h*HW +: HW] = hit ? wr_data_i : mask_q[h*HW +: HW];

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) mask_q[h*HW +: HW] <= '0;
            else        mask_q[h*HW +: HW] <= mask_d[h*HW +: HW];
        end
    end
endmodule

// File: rtl/select_view.sv
module select_view
    import irq_cause_pkg::*;
#(
    parameter int HW = 32
) (
    input  logic [2:0]      rd_addr_i,
    input  logic [2*HW-1:0] cause_i,
    input  logic [2*HW-1:0] mask_i,
    output logic [HW-1:0]   rd_data_o
);
    localparam int FLAG_HI   = HW - 2;
    localparam int FLAG_BOTH = HW - 1;

    logic [2*HW-1:0] pend;
    logic            pend_lo, pend_hi;
    logic [HW-1:0]   sel_word;

    assign pend    = cause_i & mask_i;
    assign pend_lo = |pend[HW-1:0];
    assign pend_hi = |pend[2*HW-1:HW];

    always_comb begin
        sel_word = cause_i[HW-1:0];
        if (pend_hi && !pend_lo) begin
            sel_word = cause_i[2*HW-1:HW];
            sel_word[FLAG_HI] = 1'b1;
        end else if (pend_hi && pend_lo) begin
            sel_word[FLAG_BOTH] = 1'b1;
        end
    end

    always_comb begin
        unique case (rd_addr_i)
            RA_CAUSE_LO: rd_data_o = cause_i[HW-1:0];
            RA_CAUSE_HI: rd_data_o = cause_i[2*HW-1:HW];
            RA_MASK_LO:  rd_data_o = mask_i[HW-1:0];
            RA_MASK_HI:  rd_data_o = mask_i[2*HW-1:HW];
            RA_SELECT:   rd_data_o = sel_word;
            default:     rd_data_o = '0;
        endcase
    end
endmodule

// File: rtl/irq_cause_agg.sv
module irq_cause_agg
    import irq_cause_pkg::*;
#(
    parameter int                   HW   = HALF_W,
    parameter logic [2*HW-1:0]      RSVD = RSVD_DEFAULT
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [2*HW-1:0] src_i,
    input  logic            wr_en_i,
    input  logic            wr_hi_i,
    input  logic [HW-1:0]   wr_data_i,
    input  logic [2:0]      rd_addr_i,
    output logic [HW-1:0]   rd_data_o,
    output logic            irq_o
);
    localparam int VW = 2 * HW;

    logic [VW-1:0] cause_d, cause_q;
    logic [VW-1:0] mask_d, mask_q;
    logic          irq_q;

    cause_capture #(.W(VW), .RSVD(RSVD)) u_cause (
        .clk(clk), .rst_n(rst_n), .src_i(src_i),
        .cause_d(cause_d), .cause_q(cause_q)
    );

    mask_halves #(.HW(HW)) u_mask (
        .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en_i), .wr_hi_i(wr_hi_i),
        .wr_data_i(wr_data_i), .mask_d(mask_d), .mask_q(mask_q)
    );

    select_view #(.HW(HW)) u_view (
        .rd_addr_i(rd_addr_i), .cause_i(cause_q), .mask_i(mask_q),
        .rd_data_o(rd_data_o)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= |(cause_d & mask_d);
    end

    assign irq_o = irq_q;
endmodule

// File: rtl/irq_cause_agg_chk.sv
module irq_cause_agg_chk #(
    parameter int              HW   = 32,
    parameter logic [2*HW-1:0] RSVD = '0
) (
    input logic            clk,
    input logic            rst_n,
    input logic [2*HW-1:0] src_i,
    input logic            wr_en_i,
    input logic            wr_hi_i,
    input logic [2*HW-1:0] cause_q,
    input logic [2*HW-1:0] mask_q,
    input logic            irq_o
);
    logic run_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) run_q <= 1'b0;
        else        run_q <= 1'b1;
    end

    assert_rsvd_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cause_q & RSVD) == '0);

    assert_cause_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
        run_q |-> cause_q == ($past(src_i) & ~RSVD));

    assert_lo_write_keeps_hi_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && !wr_hi_i) |=> $stable(mask_q[2*HW-1:HW]));

    assert_hi_write_keeps_lo_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && wr_hi_i) |=> $stable(mask_q[HW-1:0]));

    assert_no_write_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en_i |=> $stable(mask_q));

    assert_irq_matches_R5: assert property (@(posedge clk) disable iff (!rst_n)
        run_q |-> irq_o == (|(cause_q & mask_q)));
endmodule

bind irq_cause_agg irq_cause_agg_chk #(.HW(HW), .RSVD(RSVD)) u_chk (
    .clk(clk), .rst_n(rst_n), .src_i(src_i), .wr_en_i(wr_en_i),
    .wr_hi_i(wr_hi_i), .cause_q(cause_q), .mask_q(mask_q), .irq_o(irq_o)
);

// File: tb/sim_irq_cause_agg.sv
`timescale 1ns/1ps
module sim_irq_cause_agg;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] src = '0;
    logic        wr_en = 1'b0;
    logic        wr_hi = 1'b0;
    logic [31:0] wr_data = '0;
    logic [2:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [63:0] rsvd_m;

    always #5 clk = ~clk;

    irq_cause_agg u0 (
        .clk(clk), .rst_n(rst_n), .src_i(src), .wr_en_i(wr_en),
        .wr_hi_i(wr_hi), .wr_data_i(wr_data), .rd_addr_i(rd_addr),
        .rd_data_o(rd_data), .irq_o(irq)
    );

    function automatic bit is_rsvd(int b);
        return (b >= 29 && b <= 31) || b == 35 || (b >= 51 && b <= 55) || b >= 61;
    endfunction

    function automatic logic [31:0] sel_model(logic [63:0] c, logic [63:0] m);
        logic [63:0] p;
        p = c & m;
        if (p == 0)              return c[31:0];
        if (p[31:0] == 0)        return c[63:32] | 32'h4000_0000;
        if (p[63:32] != 0)       return c[31:0] | 32'h8000_0000;
        return c[31:0];
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic rd(logic [2:0] a, output logic [31:0] v);
        rd_addr = a;
        #1;
        v = rd_data;
    endtask

    task automatic wr_mask(logic hi, logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_hi = hi; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic set_src(logic [63:0] s);
        @(negedge clk);
        src = s;
        @(negedge clk);
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        logic [63:0] expc, cs, ms;
        for (int b = 0; b < 64; b++) rsvd_m[b] = is_rsvd(b);

        src = '1;
        repeat (3) @(negedge clk);
        // R10: reset state while reset held with all sources high
        rd(3'd0, v); chk("R10 cause lo", v, 0);
        rd(3'd1, v); chk("R10 cause hi", v, 0);
        rd(3'd2, v); chk("R10 mask lo", v, 0);
        rd(3'd3, v); chk("R10 mask hi", v, 0);
        chk("R10 irq", {31'd0, irq}, 0);
        src = '0;
        rst_n = 1'b1;

        // R1/R2: walk one source at a time
        for (int b = 0; b < 64; b++) begin
            set_src(64'd1 << b);
            expc = (64'd1 << b) & ~rsvd_m;
            rd(3'd0, v); chk("R1 R2 walk lo", v, expc[31:0]);
            rd(3'd1, v); chk("R1 R2 walk hi", v, expc[63:32]);
            chk("R5 walk no mask irq", {31'd0, irq}, 0);
        end
        set_src('1);
        rd(3'd0, v); chk("R2 all lo", v, 32'h1FFF_FFFF);
        rd(3'd1, v); chk("R2 all hi", v, 32'h1F07_FFF7);
        set_src('0);
        rd(3'd0, v); chk("R1 release lo", v, 0);

        // R3/R4: independent mask halves
        wr_mask(1'b0, 32'hA5A5_0001);
        wr_mask(1'b1, 32'h0F0F_1234);
        rd(3'd2, v); chk("R3 lo", v, 32'hA5A5_0001);
        rd(3'd3, v); chk("R4 hi", v, 32'h0F0F_1234);
        wr_mask(1'b0, 32'h1111_2222);
        rd(3'd3, v); chk("R3 hi kept", v, 32'h0F0F_1234);
        rd(3'd2, v); chk("R3 lo new", v, 32'h1111_2222);
        wr_mask(1'b1, 32'h3333_4444);
        rd(3'd2, v); chk("R4 lo kept", v, 32'h1111_2222);
        rd(3'd3, v); chk("R4 hi new", v, 32'h3333_4444);

        // R11: unmapped addresses
        for (int a = 5; a < 8; a++) begin
            rd(3'(a), v); chk("R11 unmapped", v, 0);
        end

        // R5: one-cycle latency of irq
        wr_mask(1'b0, 32'h0000_0008);
        wr_mask(1'b1, 32'h0);
        @(negedge clk);
        src = 64'h8;
        #1;
        chk("R5 irq before edge", {31'd0, irq}, 0);
        @(negedge clk);
        chk("R5 irq after edge", {31'd0, irq}, 1);
        src = 64'h0;
        #1;
        chk("R5 irq held before edge", {31'd0, irq}, 1);
        @(negedge clk);
        chk("R5 irq drop", {31'd0, irq}, 0);
        // R1: software mask write does not disturb cause
        set_src(64'h0000_0100_0000_0010);
        wr_mask(1'b0, 32'hFFFF_FFFF);
        rd(3'd0, v); chk("R1 cause unaffected by write", v, 32'h10);

        // R6..R9 grid: cause pattern x mask pattern
        for (int cp = 0; cp < 4; cp++) begin
            for (int mp = 0; mp < 4; mp++) begin
                cs = 64'h0;
                if (cp[0]) cs |= 64'h0000_0000_0400_0021;
                if (cp[1]) cs |= 64'h0A00_0100_0000_0000 | 64'h1;
                if (cp == 2) cs = 64'h0A00_0100_0000_0000;
                ms = 64'h0;
                if (mp[0]) ms[31:0]  = 32'h0400_0001;
                if (mp[1]) ms[63:32] = 32'h0000_0100;
                wr_mask(1'b0, ms[31:0]);
                wr_mask(1'b1, ms[63:32]);
                set_src(cs);
                rd(3'd4, v);
                if ((cs & ms) == 0)             chk("R6 select none", v, sel_model(cs, ms));
                else if ((cs & ms) >> 32 == 0)  chk("R9 select low only", v, sel_model(cs, ms));
                else if ((cs & ms & 64'hFFFF_FFFF) == 0) chk("R7 select high only", v, sel_model(cs, ms));
                else                            chk("R8 select both", v, sel_model(cs, ms));
                chk("R5 grid irq", {31'd0, irq}, {31'd0, |(cs & ms)});
            end
        end
        // R7 explicit: GPIO-group bit 57 alone
        wr_mask(1'b1, 32'h0200_0000);
        wr_mask(1'b0, 32'h0);
        set_src(64'h0200_0000_0000_0000 | 64'h4);
        rd(3'd4, v); chk("R7 high flag", v, 32'h4200_0000);
        wr_mask(1'b0, 32'h4);
        rd(3'd4, v); chk("R8 both flag", v, 32'h8000_0004);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule